// File: doc/BRIEF.md
# DMA Read Request Chunk Splitter

The block turns one host-memory read, described by a start address and a byte count, into a series of bus read requests. Each request carries an address and a length. The length of a request is set by three things: the selected maximum transfer size, an alignment-sensitive split mode, and the bytes still to be requested. The requests go out on a valid/grant channel. Completions come back on a single-bit response channel, one pulse per request. A programmable cap limits how many requests may be in flight at once.

Software first sets up the address, count and configuration, then pulses `start`. The block latches all of these at that moment. It keeps `busy` high until every byte has been requested and every request has been answered. It then gives a one-cycle `done` pulse and, if enabled, a matching `irq` pulse. The `remaining` output shows how many bytes have not yet been requested.

Top module: `dma_chunk_splitter`

## Requirements
- R1: After reset, `busy`, `req_valid`, `done` and `irq` are 0 and `remaining` is 0.
- R2: A `start` pulse while idle with a nonzero `byte_cnt` latches the address, the count and all configuration inputs. From the next cycle `busy` is 1 and `remaining` equals the count. It then drops by each granted length.
- R3: The size select code 0 gives 64 bytes, 1 gives 128, 2 gives 256 and 3 gives 64. A request length is the smaller of the size cap and `remaining`, and is never 0.
- R4: With split mode on, a request whose address has nonzero bits [6:0] is cut so that it does not cross the next 64-byte boundary. Its length is at most 64 minus address bits [5:0]. A 128-byte-aligned address may use the full selected size.
- R5: With split mode off, alignment has no effect and every request may use the full selected size.
- R6: Each request address equals the previous address plus the previous length. The last request carries whatever is left, even when the count is not a multiple of 4.
- R7: The limit code 0 acts as 1, and codes above 12 act as 12. `req_valid` is 0 while the outstanding count equals the limit. Each response pulse while requests are outstanding lowers the count by one.
- R8: `done` pulses for one cycle, and `busy` falls, in the cycle after the edge on which the last response is taken with `remaining` at 0. A start with a zero count gives `done` in the next cycle and issues no requests.
- R9: `irq` pulses together with `done` only when the interrupt enable latched at start is 1.
- R10: A `start` while `busy` is ignored. `remaining` and the request stream continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_max_pend | input | 4 | Outstanding request limit code |
| cfg_xfer_sel | input | 2 | Maximum transfer size select |
| cfg_split_en | input | 1 | Alignment-based split mode enable |
| cfg_irq_en | input | 1 | Raise irq on completion |
| src_addr | input | 32 | Start byte address of the read |
| byte_cnt | input | 16 | Bytes to read |
| start | input | 1 | Begin a transfer (idle only) |
| req_valid | output | 1 | Request present |
| req_grant | input | 1 | Request accepted this cycle |
| req_addr | output | 32 | Request start address |
| req_len | output | 9 | Request length in bytes |
| rsp_valid | input | 1 | One request completed |
| busy | output | 1 | Transfer in progress |
| remaining | output | 16 | Bytes not yet requested |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The request outputs are combinational from registered state. The bench therefore compares `req_valid`, `req_addr` and `req_len` within the same cycle, at the falling edge, against a cycle-by-cycle model. The effects of a grant, a response or a start are due one clock edge later. At that point `remaining`, `busy`, `done` and `irq` take their new values, and the bench applies its model update at the same edge and compares on the next falling edge. Grants and responses are drawn at random rates, so requests are often held back by the outstanding cap and responses arrive at varying times.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
    typedef enum logic [1:0] {
        SZ_64  = 2'd0,
        SZ_128 = 2'd1,
        SZ_256 = 2'd2,
        SZ_RSV = 2'd3
    } xfer_sel_e;

    localparam int MAX_CHUNK_BYTES = 256;
    localparam int PEND_CAP        = 12;
    localparam int BOUNDARY_BYTES  = 64;

    function automatic int size_bytes(input xfer_sel_e s);
        case (s)
            SZ_128:  return 128;
            SZ_256:  return 256;
            default: return 64;
        endcase
    endfunction

    function automatic logic [3:0] eff_limit(input logic [3:0] code);
        if (code == 4'd0)
            return 4'd1;
        else if (code > 4'(PEND_CAP))
            return 4'(PEND_CAP);
        else
            return code;
    endfunction
endpackage

// File: rtl/dcs_chunk_calc.sv
module dcs_chunk_calc
    import dcs_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int LW = 9
) (
    input  logic [AW-1:0] addr,
    input  logic [CW-1:0] rem,
    input  xfer_sel_e     sel,
    input  logic          split,
    output logic [LW-1:0] len
);
    logic [CW-1:0] size_c;
    logic [CW-1:0] to_bnd;
    logic [CW-1:0] cap;
    logic [CW-1:0] pick;
    logic          unaligned;

    always_comb begin
        size_c    = CW'(size_bytes(sel));
        to_bnd    = CW'(7'd64 - {1'b0, addr[5:0]});
        unaligned = (addr[6:0] != 7'd0);
        cap       = (split && unaligned && (to_bnd < size_c)) ? to_bnd : size_c;
        pick      = (rem < cap) ? rem : cap;
        len       = pick[LW-1:0];
    end
endmodule

// File: rtl/dcs_pend_ctr.sv
module dcs_pend_ctr #(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    input  logic [PW-1:0] lim,
    output logic [PW-1:0] cnt,
    output logic [PW-1:0] cnt_nxt,
    output logic          room
);
    logic [PW-1:0] cnt_d, cnt_q;
    logic          dec_ok;

    always_comb begin
        dec_ok = dec && (cnt_q != '0);
        cnt_d  = cnt_q;
        if (inc && !dec_ok)
            cnt_d = cnt_q + 1'b1;
        else if (dec_ok && !inc)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign cnt     = cnt_q;
    assign cnt_nxt = cnt_d;
    assign room    = (cnt_q < lim);

    assert_pend_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim)
        else $error("outstanding count above limit");

    assert_no_grant_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == lim) |-> !inc)
        else $error("request accepted at the outstanding limit");
endmodule

// File: rtl/dma_chunk_splitter.sv
module dma_chunk_splitter
    import dcs_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int PW = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [PW-1:0]                       cfg_max_pend,
    input  logic [1:0]                          cfg_xfer_sel,
    input  logic                                cfg_split_en,
    input  logic                                cfg_irq_en,
    input  logic [AW-1:0]                       src_addr,
    input  logic [CW-1:0]                       byte_cnt,
    input  logic                                start,
    output logic                                req_valid,
    input  logic                                req_grant,
    output logic [AW-1:0]                       req_addr,
    output logic [$clog2(MAX_CHUNK_BYTES):0]    req_len,
    input  logic                                rsp_valid,
    output logic                                busy,
    output logic [CW-1:0]                       remaining,
    output logic                                done,
    output logic                                irq
);
    localparam int LW = $clog2(MAX_CHUNK_BYTES) + 1;

    typedef struct packed {
        logic          busy;
        logic [AW-1:0] addr;
        logic [CW-1:0] rem;
        xfer_sel_e     sel;
        logic          split;
        logic          irq_en;
        logic [PW-1:0] lim;
        logic          done;
        logic          irq;
    } state_t;

    state_t        st_d, st_q;
    logic [LW-1:0] len_w;
    logic [PW-1:0] pend_cnt, pend_nxt;
    logic          pend_room;
    logic          fire;

    dcs_chunk_calc #(.AW(AW), .CW(CW), .LW(LW)) u_calc (
        .addr  (st_q.addr),
        .rem   (st_q.rem),
        .sel   (st_q.sel),
        .split (st_q.split),
        .len   (len_w)
    );

    dcs_pend_ctr #(.PW(PW)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (fire),
        .dec     (rsp_valid),
        .lim     (st_q.lim),
        .cnt     (pend_cnt),
        .cnt_nxt (pend_nxt),
        .room    (pend_room)
    );

    assign req_valid = st_q.busy && (st_q.rem != '0) && pend_room;
    assign fire      = req_valid && req_grant;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.irq  = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                if (byte_cnt == '0) begin
                    st_d.done = 1'b1;
                    st_d.irq  = cfg_irq_en;
                end else begin
                    st_d.busy   = 1'b1;
                    st_d.addr   = src_addr;
                    st_d.rem    = byte_cnt;
                    st_d.sel    = xfer_sel_e'(cfg_xfer_sel);
                    st_d.split  = cfg_split_en;
                    st_d.irq_en = cfg_irq_en;
                    st_d.lim    = eff_limit(cfg_max_pend);
                end
            end
        end else begin
            if (fire) begin
                st_d.addr = st_q.addr + AW'(len_w);
                st_d.rem  = st_q.rem - CW'(len_w);
            end
            if ((st_d.rem == '0) && (pend_nxt == '0)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.irq  = st_q.irq_en;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.sel    <= SZ_64;
            st_q.lim    <= PW'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign req_addr  = st_q.addr;
    assign req_len   = len_w;
    assign busy      = st_q.busy;
    assign remaining = st_q.rem;
    assign done      = st_q.done;
    assign irq       = st_q.irq;

    assert_len_bounds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len != '0) && (CW'(req_len) <= remaining)
                      && (req_len <= LW'(size_bytes(st_q.sel))))
        else $error("request length out of bounds");

    assert_split_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && st_q.split && (req_addr[6:0] != 7'd0))
            |-> (({3'd0, req_addr[5:0]} + req_len) <= LW'(BOUNDARY_BYTES)))
        else $error("split request crosses a 64-byte boundary");

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy)
        else $error("done while still busy");

    assert_irq_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done)
        else $error("irq without done");

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !fire) |=> ($stable(remaining) && $stable(req_addr)))
        else $error("start while busy changed the transfer");
endmodule

// File: tb/dma_chunk_splitter_bench.sv
module dma_chunk_splitter_bench;
    localparam int AW = 32;
    localparam int CW = 16;
    localparam int PW = 4;
    localparam int LW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] cfg_max_pend = '0;
    logic [1:0]    cfg_xfer_sel = '0;
    logic          cfg_split_en = 1'b0;
    logic          cfg_irq_en = 1'b0;
    logic [AW-1:0] src_addr = '0;
    logic [CW-1:0] byte_cnt = '0;
    logic          start = 1'b0;
    logic          req_valid;
    logic          req_grant = 1'b0;
    logic [AW-1:0] req_addr;
    logic [LW-1:0] req_len;
    logic          rsp_valid = 1'b0;
    logic          busy;
    logic [CW-1:0] remaining;
    logic          done;
    logic          irq;

    dma_chunk_splitter #(.AW(AW), .CW(CW), .PW(PW)) u_dma_chunk_splitter (
        .clk(clk), .rst_n(rst_n),
        .cfg_max_pend(cfg_max_pend), .cfg_xfer_sel(cfg_xfer_sel),
        .cfg_split_en(cfg_split_en), .cfg_irq_en(cfg_irq_en),
        .src_addr(src_addr), .byte_cnt(byte_cnt), .start(start),
        .req_valid(req_valid), .req_grant(req_grant),
        .req_addr(req_addr), .req_len(req_len), .rsp_valid(rsp_valid),
        .busy(busy), .remaining(remaining), .done(done), .irq(irq)
    );

    always #2.5 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit hung    = 1'b0;

    // reference model state
    bit          m_busy, m_done, m_irq, m_irqen, m_split;
    logic [31:0] m_addr;
    int          m_rem, m_pend, m_lim, m_sel;
    bit          r10_tag;

    // stimulus settings
    logic [31:0] s_addr;
    int          s_cnt, s_sel, s_lim, gp, rp;
    bit          s_split, s_irq;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int sz_of(input int sel);
        return (sel == 1) ? 128 : (sel == 2) ? 256 : 64;
    endfunction

    function automatic int lim_of(input int code);
        return (code == 0) ? 1 : (code > 12) ? 12 : code;
    endfunction

    function automatic int cap_of(input logic [31:0] a, input int sel, input bit split);
        int c = sz_of(sel);
        int b = 64 - int'(a[5:0]);
        if (split && a[6:0] != 7'd0 && b < c) c = b;
        return c;
    endfunction

    task automatic step(input bit st);
        bit ev, g, r;
        int cap, el;
        // compare at the falling edge
        chk({31'd0, busy}, {31'd0, m_busy}, "R2 busy");
        chk(32'(remaining), 32'(m_rem), r10_tag ? "R10 remaining" : "R2 remaining");
        chk({31'd0, done}, {31'd0, m_done}, "R8 done");
        chk({31'd0, irq}, {31'd0, m_irq}, "R9 irq");
        r10_tag = 1'b0;
        ev = m_busy && (m_rem != 0) && (m_pend < m_lim);
        chk({31'd0, req_valid}, {31'd0, ev}, "R7 req_valid");
        cap = cap_of(m_addr, m_sel, m_split);
        el  = (m_rem < cap) ? m_rem : cap;
        if (ev && req_valid) begin
            chk(req_addr, m_addr, "R6 req_addr");
            if (m_rem < cap)
                chk(32'(req_len), 32'(el), "R6 last len");
            else if (m_split && m_addr[6:0] != 7'd0)
                chk(32'(req_len), 32'(el), "R4 split len");
            else if (!m_split && m_addr[6:0] != 7'd0)
                chk(32'(req_len), 32'(el), "R5 nosplit len");
            else
                chk(32'(req_len), 32'(el), "R3 size len");
        end
        // drive
        g = ($urandom % 100) < gp;
        r = (m_pend > 0) && (($urandom % 100) < rp);
        start        = st;
        src_addr     = s_addr;
        byte_cnt     = CW'(s_cnt);
        cfg_xfer_sel = 2'(s_sel);
        cfg_split_en = s_split;
        cfg_irq_en   = s_irq;
        cfg_max_pend = PW'(s_lim);
        req_grant    = g;
        rsp_valid    = r;
        // model the coming edge
        m_done = 1'b0;
        m_irq  = 1'b0;
        if (!m_busy) begin
            if (st) begin
                if (s_cnt == 0) begin
                    m_done = 1'b1;
                    m_irq  = s_irq;
                end else begin
                    m_busy = 1'b1; m_addr = s_addr; m_rem = s_cnt;
                    m_sel = s_sel; m_split = s_split; m_irqen = s_irq;
                    m_lim = lim_of(s_lim);
                end
            end
        end else begin
            if (st) r10_tag = 1'b1;
            if (ev && g) begin
                m_addr = m_addr + 32'(el);
                m_rem  = m_rem - el;
            end
            m_pend = m_pend + ((ev && g) ? 1 : 0) - (r ? 1 : 0);
            if (m_rem == 0 && m_pend == 0) begin
                m_busy = 1'b0;
                m_done = 1'b1;
                m_irq  = m_irqen;
            end
        end
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cycles++;
    endtask

    task automatic run_xfer(input logic [31:0] a, input int c, input int sel, input bit split,
                            input bit irqe, input int lim, input int gpp, input int rpp,
                            input bit restart);
        int n = 0;
        s_addr = a; s_cnt = c; s_sel = sel; s_split = split; s_irq = irqe; s_lim = lim;
        gp = gpp; rp = rpp;
        step(1'b1);
        while ((m_busy || m_done) && !hung) begin
            n++;
            if (restart && n == 3) begin
                s_cnt = 77; s_addr = 32'h0000_5000;
                step(1'b1);
            end else begin
                step(1'b0);
            end
            if (cycles > 150000) begin
                hung = 1'b1;
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual hung expected finish");
            end
        end
    endtask

    initial begin
        m_busy = 0; m_done = 0; m_irq = 0; m_irqen = 0; m_split = 0;
        m_addr = 0; m_rem = 0; m_pend = 0; m_lim = 1; m_sel = 0; r10_tag = 0;
        s_addr = 0; s_cnt = 0; s_sel = 0; s_lim = 1; gp = 100; rp = 100;
        s_split = 0; s_irq = 0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({31'd0, busy}, 32'd0, "R1 busy");
        chk({31'd0, req_valid}, 32'd0, "R1 req_valid");
        chk({31'd0, done}, 32'd0, "R1 done");
        chk({31'd0, irq}, 32'd0, "R1 irq");
        chk(32'(remaining), 32'd0, "R1 remaining");
        rst_n = 1'b1;
        @(negedge clk);
        // directed corners
        run_xfer(32'h0000_1080, 300, 1, 1'b1, 1'b1, 4, 100, 100, 1'b0); // R4 aligned full 128
        run_xfer(32'h0000_1030, 300, 1, 1'b1, 1'b1, 4, 100, 60, 1'b0);  // R4 unaligned
        run_xfer(32'h0000_1030, 300, 2, 1'b0, 1'b0, 2, 100, 60, 1'b0);  // R5
        run_xfer(32'h0000_2000, 0, 0, 1'b0, 1'b1, 3, 100, 100, 1'b0);   // R8 zero count
        run_xfer(32'h0000_2003, 1, 2, 1'b1, 1'b1, 3, 100, 100, 1'b0);   // R6 one byte
        run_xfer(32'h0000_3000, 203, 0, 1'b0, 1'b0, 0, 100, 30, 1'b0);  // R7 code 0
        run_xfer(32'h0000_3000, 1500, 0, 1'b0, 1'b1, 15, 100, 10, 1'b0); // R7 clamp
        run_xfer(32'h0000_4010, 900, 1, 1'b1, 1'b1, 2, 80, 50, 1'b1);   // R10 restart
        for (int i = 0; i < 60 && !hung; i++) begin
            run_xfer($urandom, int'($urandom % 700), int'($urandom % 4), 1'($urandom),
                     1'($urandom), int'($urandom % 16), 20 + int'($urandom % 81),
                     15 + int'($urandom % 86), 1'b0);
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule